// File: doc/BRIEF.md
# Two-Thread Instruction Cache Bank Partitioner

This block sits in the fetch stage of a two-thread simultaneous multithreading core, next to an instruction cache that is split into several banks. Each cycle it looks at the fetch address and valid bit of both threads and works out which thread may fetch. When both addresses select the same bank, it raises a conflict flag and grants only one of them. A round-robin pointer picks the winner. When the two threads use different banks, both are granted, whatever the ownership.

It also keeps a bank ownership map that says which thread each bank belongs to. Cache refill is gated by this map: a miss by one thread can only write lines into a bank that thread owns. The map is rebuilt once per fixed-length interval. In static mode the banks are split evenly. In dynamic mode the share of the faster thread grows by one bank per interval, as long as its progress count leads by more than a grow threshold. A floor threshold guarantees a minimum number of banks to the slower thread.

The cache arrays, tags, miss handling and wider thread scheduling stay outside the block. All outputs are registered, so each output reflects the inputs of the previous clock edge.

Top module: `bank_partitioner`

## Requirements
- R1: While reset is held, fetch grants, conflict flag and refill enables are all zero, and the ownership map holds the even static split, 8'hF0. The interval counter restarts at zero, so the first ownership update happens on the 256th clock edge after reset is released.
- R2: The bank of a fetch address is address bits [5:3]. When both threads are valid and select the same bank, conflict_o is 1 one cycle later; otherwise it is 0.
- R3: Without a conflict, grant_o (bit 0 thread 0, bit 1 thread 1) equals the two valid bits one cycle later. This holds even for a thread whose bank belongs to the other thread.
- R4: On a conflict exactly one grant bit is set. The winner is given by a round-robin pointer that starts at thread 0 after reset and toggles after every conflict.
- R5: Bit i of own_mask_o is 1 when thread 1 owns bank i. Thread 1 owns the top q banks, where q is its quota. At an interval boundary with dyn_mode_i at 0, the quota becomes 4 and the map becomes 8'hF0.
- R6: The ownership map changes only at the clock edge that ends each 256-cycle interval.
- R7: At a boundary with dyn_mode_i at 1: if prog1_i > prog0_i + thr_grow_i, thread 1's quota rises by one. Otherwise, if prog0_i > prog1_i + thr_grow_i, it falls by one. Otherwise it is kept.
- R8: In dynamic mode a quota change is skipped if it would leave the losing thread with fewer than thr_floor_i banks. With a floor of 0, one thread may own all eight banks.
- R9: refill_en_o is one-hot at bit refill_bank_i one cycle after refill_req_i, but only when that bank belongs to refill_tid_i in the current map. Otherwise refill_en_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc0_i | input | 32 | Thread 0 fetch address |
| pc_vld0_i | input | 1 | Thread 0 fetch request |
| pc1_i | input | 32 | Thread 1 fetch address |
| pc_vld1_i | input | 1 | Thread 1 fetch request |
| prog0_i | input | 16 | Thread 0 progress count for the interval |
| prog1_i | input | 16 | Thread 1 progress count for the interval |
| dyn_mode_i | input | 1 | 0 static split, 1 dynamic quota |
| thr_grow_i | input | 16 | Lead needed before the fast thread gains a bank |
| thr_floor_i | input | 4 | Minimum bank count kept by the slow thread |
| refill_req_i | input | 1 | Refill write request |
| refill_tid_i | input | 1 | Thread that missed |
| refill_bank_i | input | 3 | Bank targeted by the refill |
| own_mask_o | output | 8 | Bank ownership, 1 = thread 1 |
| grant_o | output | 2 | Fetch grant per thread |
| conflict_o | output | 1 | Both threads hit one bank |
| refill_en_o | output | 8 | Per-bank refill write enable |

## Verification
The floor property assumes that the map already meets the floor when a boundary arrives. The bench keeps to this by raising the floor only while the quota sits inside it, and by lowering it to zero before pushing one thread to all banks. The stability and step properties assume the progress counts and thresholds are held steady across each boundary edge, and the bench changes them only between intervals. Grant and refill properties take the inputs as arbitrary. The bench sweeps every bank pair under every valid pattern, and every refill thread, bank and request combination under three different maps.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    PART_STATIC  = 1'b0,
    PART_DYNAMIC = 1'b1
  } part_mode_e;

  typedef logic [1:0] tid_vec_t;
endpackage

// File: rtl/bp_conflict_arb.sv
module bp_conflict_arb #(
  parameter int BW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BW-1:0]   bank0,
  input  logic            vld0,
  input  logic [BW-1:0]   bank1,
  input  logic            vld1,
  output bp_pkg::tid_vec_t grant,
  output logic            conflict
);
  logic             rr_q;
  logic             hit;
  bp_pkg::tid_vec_t grant_n;

  always_comb begin
    hit = vld0 && vld1 && (bank0 == bank1);
    if (hit) grant_n = rr_q ? 2'b10 : 2'b01;
    else     grant_n = {vld1, vld0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= '0;
      conflict <= 1'b0;
      rr_q     <= 1'b0;
    end else begin
      grant    <= grant_n;
      conflict <= hit;
      if (hit) rr_q <= ~rr_q;
    end
  end
endmodule

// File: rtl/bp_quota_ctrl.sv
module bp_quota_ctrl #(
  parameter int NBANK    = 8,
  parameter int CNT_W    = 16,
  parameter int INTERVAL = 256
) (
  input  logic                        clk,
  input  logic                        rst,
  input  bp_pkg::part_mode_e          mode,
  input  logic [CNT_W-1:0]            prog0,
  input  logic [CNT_W-1:0]            prog1,
  input  logic [CNT_W-1:0]            thr_grow,
  input  logic [$clog2(NBANK+1)-1:0]  thr_floor,
  output logic [NBANK-1:0]            mask
);
  localparam int QW   = $clog2(NBANK + 1);
  localparam int IW   = $clog2(INTERVAL);
  localparam int HALF = NBANK / 2;

  function automatic logic [NBANK-1:0] mask_of(input logic [QW-1:0] q);
    logic [NBANK-1:0] m;
    for (int i = 0; i < NBANK; i++)
      m[i] = ((QW+1)'(i) + {1'b0, q}) >= (QW+1)'(NBANK);
    return m;
  endfunction

  logic [IW-1:0]    ivl_cnt;
  logic [QW-1:0]    quota, quota_n;
  logic             boundary;
  logic [CNT_W:0]   lim0, lim1;
  logic             fast1, fast0, room1, room0;

  always_comb begin
    boundary = (ivl_cnt == IW'(INTERVAL - 1));
    lim0  = {1'b0, prog0} + {1'b0, thr_grow};
    lim1  = {1'b0, prog1} + {1'b0, thr_grow};
    fast1 = {1'b0, prog1} > lim0;
    fast0 = {1'b0, prog0} > lim1;
    room1 = ({1'b0, quota} + (QW+1)'(1) + {1'b0, thr_floor}) <= (QW+1)'(NBANK);
    room0 = quota > thr_floor;
    if (mode == bp_pkg::PART_STATIC) quota_n = QW'(HALF);
    else if (fast1 && room1)         quota_n = quota + QW'(1);
    else if (fast0 && room0)         quota_n = quota - QW'(1);
    else                             quota_n = quota;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_cnt <= '0;
      quota   <= QW'(HALF);
      mask    <= mask_of(QW'(HALF));
    end else begin
      ivl_cnt <= boundary ? '0 : ivl_cnt + IW'(1);
      if (boundary) begin
        quota <= quota_n;
        mask  <= mask_of(quota_n);
      end
    end
  end
endmodule

// File: rtl/bp_refill_gate.sv
module bp_refill_gate #(
  parameter int NBANK = 8,
  parameter int BW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             tid,
  input  logic [BW-1:0]    bank,
  input  logic [NBANK-1:0] mask,
  output logic [NBANK-1:0] en
);
  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) en[i] <= 1'b0;
      else     en[i] <= req && (bank == BW'(i)) && (mask[i] == tid);
    end
  end
endmodule

// File: rtl/bank_partitioner.sv
module bank_partitioner #(
  parameter int NBANK    = 8,
  parameter int PC_W     = 32,
  parameter int BANK_LSB = 3,
  parameter int CNT_W    = 16,
  parameter int INTERVAL = 256,
  localparam int BW      = $clog2(NBANK),
  localparam int QW      = $clog2(NBANK + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   pc0_i,
  input  logic              pc_vld0_i,
  input  logic [PC_W-1:0]   pc1_i,
  input  logic              pc_vld1_i,
  input  logic [CNT_W-1:0]  prog0_i,
  input  logic [CNT_W-1:0]  prog1_i,
  input  logic              dyn_mode_i,
  input  logic [CNT_W-1:0]  thr_grow_i,
  input  logic [QW-1:0]     thr_floor_i,
  input  logic              refill_req_i,
  input  logic              refill_tid_i,
  input  logic [BW-1:0]     refill_bank_i,
  output logic [NBANK-1:0]  own_mask_o,
  output logic [1:0]        grant_o,
  output logic              conflict_o,
  output logic [NBANK-1:0]  refill_en_o
);
  bp_pkg::part_mode_e mode;
  logic [BW-1:0]      bank0, bank1;

  always_comb begin
    mode  = bp_pkg::part_mode_e'(dyn_mode_i);
    bank0 = pc0_i[BANK_LSB +: BW];
    bank1 = pc1_i[BANK_LSB +: BW];
  end

  bp_conflict_arb #(.BW(BW)) u_arb (
    .clk(clk), .rst(rst),
    .bank0(bank0), .vld0(pc_vld0_i),
    .bank1(bank1), .vld1(pc_vld1_i),
    .grant(grant_o), .conflict(conflict_o)
  );

  bp_quota_ctrl #(.NBANK(NBANK), .CNT_W(CNT_W), .INTERVAL(INTERVAL)) u_quota (
    .clk(clk), .rst(rst), .mode(mode),
    .prog0(prog0_i), .prog1(prog1_i),
    .thr_grow(thr_grow_i), .thr_floor(thr_floor_i),
    .mask(own_mask_o)
  );

  bp_refill_gate #(.NBANK(NBANK), .BW(BW)) u_refill (
    .clk(clk), .rst(rst),
    .req(refill_req_i), .tid(refill_tid_i), .bank(refill_bank_i),
    .mask(own_mask_o), .en(refill_en_o)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int NBANK    = 8,
  parameter int PC_W     = 32,
  parameter int BANK_LSB = 3,
  parameter int INTERVAL = 256,
  localparam int BW      = $clog2(NBANK),
  localparam int QW      = $clog2(NBANK + 1),
  localparam int IW      = $clog2(INTERVAL)
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  pc0_i,
  input logic             pc_vld0_i,
  input logic [PC_W-1:0]  pc1_i,
  input logic             pc_vld1_i,
  input logic             dyn_mode_i,
  input logic [QW-1:0]    thr_floor_i,
  input logic             refill_req_i,
  input logic             refill_tid_i,
  input logic [NBANK-1:0] own_mask_o,
  input logic [1:0]       grant_o,
  input logic             conflict_o,
  input logic [NBANK-1:0] refill_en_o
);
  logic [IW-1:0] chk_cnt;
  logic          at_edge;
  logic          same_bank;

  always_ff @(posedge clk) begin
    if (rst) chk_cnt <= '0;
    else     chk_cnt <= (chk_cnt == IW'(INTERVAL - 1)) ? '0 : chk_cnt + IW'(1);
  end

  always_comb begin
    at_edge   = (chk_cnt == IW'(INTERVAL - 1));
    same_bank = pc_vld0_i && pc_vld1_i &&
                (pc0_i[BANK_LSB +: BW] == pc1_i[BANK_LSB +: BW]);
  end

  p_conflict_flag_r2: assert property (@(posedge clk) disable iff (rst)
    same_bank |=> conflict_o);

  p_free_grant_r3: assert property (@(posedge clk) disable iff (rst)
    !same_bank |=> (grant_o == {$past(pc_vld1_i), $past(pc_vld0_i)}) && !conflict_o);

  p_single_winner_r4: assert property (@(posedge clk) disable iff (rst)
    conflict_o |-> $countones(grant_o) == 1);

  p_static_split_r5: assert property (@(posedge clk) disable iff (rst)
    (at_edge && !dyn_mode_i) |=> $countones(own_mask_o) == NBANK / 2 && own_mask_o[NBANK-1]);

  p_hold_mid_interval_r6: assert property (@(posedge clk) disable iff (rst)
    !at_edge |=> $stable(own_mask_o));

  p_one_step_r7: assert property (@(posedge clk) disable iff (rst)
    dyn_mode_i |=> ($countones(own_mask_o) <= $countones($past(own_mask_o)) + 1) &&
                   ($countones(own_mask_o) + 1 >= $countones($past(own_mask_o))));

  p_floor_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (at_edge && dyn_mode_i && ($countones(own_mask_o) >= int'(thr_floor_i)) &&
     (NBANK - $countones(own_mask_o) >= int'(thr_floor_i)))
    |=> ($countones(own_mask_o) >= int'($past(thr_floor_i))) &&
        (NBANK - $countones(own_mask_o) >= int'($past(thr_floor_i))));

  p_refill_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    refill_req_i |=> $onehot0(refill_en_o) &&
      ((refill_en_o & ($past(refill_tid_i) ? ~$past(own_mask_o) : $past(own_mask_o))) == '0));

  p_refill_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !refill_req_i |=> refill_en_o == '0);
endmodule

bind bank_partitioner bp_checker #(
  .NBANK(NBANK), .PC_W(PC_W), .BANK_LSB(BANK_LSB), .INTERVAL(INTERVAL)
) u_chk (
  .clk(clk), .rst(rst),
  .pc0_i(pc0_i), .pc_vld0_i(pc_vld0_i), .pc1_i(pc1_i), .pc_vld1_i(pc_vld1_i),
  .dyn_mode_i(dyn_mode_i), .thr_floor_i(thr_floor_i),
  .refill_req_i(refill_req_i), .refill_tid_i(refill_tid_i),
  .own_mask_o(own_mask_o), .grant_o(grant_o), .conflict_o(conflict_o),
  .refill_en_o(refill_en_o)
);

// File: tb/sim_bank_partitioner.sv
module sim_bank_partitioner;
  localparam int NB = 8;
  localparam int IVL = 256;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc0_i, pc1_i;
  logic        pc_vld0_i, pc_vld1_i;
  logic [15:0] prog0_i, prog1_i, thr_grow_i;
  logic        dyn_mode_i;
  logic [3:0]  thr_floor_i;
  logic        refill_req_i, refill_tid_i;
  logic [2:0]  refill_bank_i;
  logic [7:0]  own_mask_o, refill_en_o;
  logic [1:0]  grant_o;
  logic        conflict_o;

  int nchk = 0, nerr = 0, cyc = 0, q_m = NB / 2;
  bit rr_m = 1'b0;

  always #10 clk = ~clk;

  bank_partitioner u0 (.*);

  function automatic logic [7:0] map_of(input int q);
    logic [7:0] m;
    for (int i = 0; i < NB; i++) m[i] = (i >= NB - q);
    return m;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [1:0] eg;
    logic       ec;
    logic [7:0] er;
    int         old_q;
    bit         bnd;
    string      mtag;
    ec = pc_vld0_i && pc_vld1_i && (pc0_i[5:3] == pc1_i[5:3]);
    eg = ec ? (rr_m ? 2'b10 : 2'b01) : {pc_vld1_i, pc_vld0_i};
    if (ec) rr_m = ~rr_m;
    er = '0;
    if (refill_req_i && (own_mask_o[refill_bank_i] == refill_tid_i)) er[refill_bank_i] = 1'b1;
    cyc++;
    bnd = (cyc % IVL) == 0;
    old_q = q_m;
    if (bnd) begin
      if (!dyn_mode_i) q_m = NB / 2;
      else if (int'(prog1_i) > int'(prog0_i) + int'(thr_grow_i) && q_m + 1 + int'(thr_floor_i) <= NB) q_m++;
      else if (int'(prog0_i) > int'(prog1_i) + int'(thr_grow_i) && q_m > int'(thr_floor_i)) q_m--;
    end
    if (!bnd) mtag = "R6";
    else if (!dyn_mode_i) mtag = "R5";
    else if (q_m != old_q) mtag = "R7";
    else mtag = "R8";
    @(negedge clk);
    chk(ec ? "R4 grant" : "R3 grant", 32'(grant_o), 32'(eg));
    chk("R2 conflict", 32'(conflict_o), 32'(ec));
    chk("R9 refill", 32'(refill_en_o), 32'(er));
    chk({mtag, " map"}, 32'(own_mask_o), 32'(map_of(q_m)));
  endtask

  task automatic run_ivls(input int n);
    int seen = 0;
    while (seen < n) begin
      pc0_i = 32'(cyc * 8);
      pc1_i = 32'(cyc * 24 + 5);
      pc_vld0_i = 1'b1;
      pc_vld1_i = (cyc % 5) != 0;
      step();
      if ((cyc % IVL) == 0) seen++;
    end
  endtask

  task automatic refill_sweep();
    pc_vld0_i = 1'b0;
    pc_vld1_i = 1'b0;
    for (int t = 0; t < 2; t++)
      for (int b = 0; b < NB; b++)
        for (int r = 0; r < 2; r++) begin
          refill_tid_i  = t[0];
          refill_bank_i = 3'(b);
          refill_req_i  = r[0];
          step();
        end
    refill_req_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    pc0_i = '0; pc1_i = '0; pc_vld0_i = 1'b0; pc_vld1_i = 1'b0;
    prog0_i = '0; prog1_i = '0; thr_grow_i = '0; thr_floor_i = '0;
    dyn_mode_i = 1'b0; refill_req_i = 1'b0; refill_tid_i = 1'b0; refill_bank_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 grant", 32'(grant_o), 32'h0);
    chk("R1 conflict", 32'(conflict_o), 32'h0);
    chk("R1 refill", 32'(refill_en_o), 32'h0);
    chk("R1 map", 32'(own_mask_o), 32'hF0);
    rst = 1'b0;

    // R2 R3 R4: every bank pair under every valid pattern
    for (int vp = 0; vp < 4; vp++)
      for (int b0 = 0; b0 < NB; b0++)
        for (int b1 = 0; b1 < NB; b1++) begin
          pc_vld0_i = vp[0];
          pc_vld1_i = vp[1];
          pc0_i = 32'((vp << 12) | (b0 << 3) | (b1 & 7));
          pc1_i = 32'((b0 << 9) | (b1 << 3) | 2);
          step();
        end

    // R9 under the static map
    refill_sweep();

    // R7 growth for thread 1, then R8 floor of 2 stops it at 6
    dyn_mode_i = 1'b1; thr_grow_i = 16'd10; thr_floor_i = 4'd2;
    prog1_i = 16'd100; prog0_i = 16'd50;
    run_ivls(4);
    chk("R8 quota capped", 32'(own_mask_o), 32'hFC);

    // R7 thread 0 becomes faster, R8 floor stops at 2
    prog0_i = 16'd200; prog1_i = 16'd20;
    run_ivls(5);
    chk("R8 floor held", 32'(own_mask_o), 32'hC0);

    // R7 lead equal to threshold: no change
    prog0_i = 16'd60; prog1_i = 16'd50;
    run_ivls(1);
    chk("R7 no move", 32'(own_mask_o), 32'hC0);

    // R9 under a skewed map
    refill_sweep();

    // R8 floor of zero lets thread 1 own every bank
    thr_floor_i = 4'd0; prog1_i = 16'd500; prog0_i = 16'd0;
    run_ivls(7);
    chk("R8 full ownership", 32'(own_mask_o), 32'hFF);
    refill_sweep();

    // R5 return to static split
    dyn_mode_i = 1'b0;
    run_ivls(1);
    chk("R5 static restored", 32'(own_mask_o), 32'hF0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule